// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block decides, for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback), whether the instruction in decode must be held back and where each execute-stage operand should come from. It compares register numbers and instruction-class flags from the decode stage and the three pipeline registers behind it. It then drives the bypass selects for the two ALU operands and for the store-data path into data memory. It also drives the front-end controls that freeze the program counter and the decode register and that inject a bubble into execute. The block is purely combinational. The register file, ALU, data memory and the muxes themselves sit outside it.

A load followed at once by an instruction that uses the loaded value as an ALU or address input costs one stall cycle. After that cycle the loaded value is bypassed from the memory/writeback register. ALU results are bypassed from the execute/memory register with no stall. The register file is assumed to write early and read late in a cycle, so a producer three instructions ahead needs no bypass. A store whose data register comes from the load just before it does not stall: the loaded value is steered into the data-memory input one stage later.

Top module: `hazardUnit`

## Requirements
- R1: With a load in execute whose destination is nonzero, a decode instruction of any class that names that register as its first source, or an ALU instruction that names it as its second source, gives `pcWrite`=0, `ifIdWrite`=0, `idExFlush`=1. In every other case the outputs are 1, 1, 0.
- R2: A store in decode whose only match with the load in execute is its data (second) register does not stall.
- R3: When the execute/memory register holds an ALU result for a nonzero register that an execute operand reads, that operand's select is 2'b01.
- R4: When only the memory/writeback register holds an ALU or load result for a nonzero register that an execute operand reads, that operand's select is 2'b10. With no match the select is 2'b00, meaning the register file value.
- R5: When both the execute/memory and the memory/writeback registers match an operand, the select is 2'b01, so the newer value wins.
- R6: `aluSelA` follows the first source and `aluSelB` follows the second source of an ALU instruction in execute. Each one is decided independently, so both can bypass from different stages in the same cycle.
- R7: Register 0 never produces a bypass or a stall.
- R8: A producer in writeback has no effect on any output for a consumer in decode.
- R9: For a store in execute, `exStoreSel` selects the data register from the execute/memory ALU result (2'b01) or from memory/writeback (2'b10). `aluSelB` stays 2'b00. For an instruction that is not a store, `exStoreSel` is 2'b00.
- R10: When the execute/memory stage holds a load that matches the store data register in execute, `exStoreSel` is 2'b00, even if an older memory/writeback value matches. When a store in memory has its data register written by a load in writeback, `memStoreFwd` is 1.
- R11: An execute stage with no class flag set (a bubble) gets all selects at 2'b00. A store in a later stage is never a bypass source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | REG_W | Decode first source register |
| idRs2 | input | REG_W | Decode second source register (store data for stores) |
| idIsAlu | input | 1 | Decode holds an ALU instruction |
| idIsLoad | input | 1 | Decode holds a load |
| idIsStore | input | 1 | Decode holds a store |
| exRs1 | input | REG_W | Execute first source register |
| exRs2 | input | REG_W | Execute second source register |
| exRd | input | REG_W | Execute destination register |
| exIsAlu | input | 1 | Execute holds an ALU instruction |
| exIsLoad | input | 1 | Execute holds a load |
| exIsStore | input | 1 | Execute holds a store |
| memRd | input | REG_W | Execute/memory destination register |
| memRs2 | input | REG_W | Execute/memory store data register |
| memIsAlu | input | 1 | Execute/memory holds an ALU result |
| memIsLoad | input | 1 | Execute/memory holds a load |
| memIsStore | input | 1 | Execute/memory holds a store |
| wbRd | input | REG_W | Memory/writeback destination register |
| wbIsAlu | input | 1 | Memory/writeback holds an ALU result |
| wbIsLoad | input | 1 | Memory/writeback holds loaded data |
| pcWrite | output | 1 | Program counter update enable |
| ifIdWrite | output | 1 | Decode register update enable |
| idExFlush | output | 1 | Insert a bubble into execute |
| aluSelA | output | 2 | First ALU operand source select |
| aluSelB | output | 2 | Second ALU operand source select |
| exStoreSel | output | 2 | Store data source select in execute |
| memStoreFwd | output | 1 | Replace store data with loaded value in memory stage |

## Verification
On every input change the assertions check several properties. The three stall controls always move together, and a stall only ever has a nonzero load destination in execute as its cause. A 2'b01 or 2'b10 select always has a real matching producer behind it. The newer stage always wins an overlap, and the late store bypass only fires with a load in writeback. Only the bench's scenarios can show the positive side. They show that every dependency pattern really does produce the expected select. They also show that a store-data match on a load does not stall and that a writeback-to-decode distance leaves every output idle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int SRC_N = 3;
  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
  localparam int SRC_S = 2;

  typedef enum logic [1:0] {
    SEL_REG   = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwdSel_t;

  typedef struct packed {
    logic newAlu;
    logic newLoad;
    logic oldHit;
  } srcHit_t;

  typedef struct packed {
    srcHit_t [SRC_N-1:0] hit;
    logic                loadUse;
    logic                lateStore;
  } ctlStrobe_t;
endpackage

// File: rtl/hazardCtl.sv
module hazardCtl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idIsAlu,
  input  logic             idIsLoad,
  input  logic             idIsStore,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exIsAlu,
  input  logic             exIsLoad,
  input  logic             exIsStore,
  input  logic [REG_W-1:0] memRd,
  input  logic [REG_W-1:0] memRs2,
  input  logic             memIsAlu,
  input  logic             memIsLoad,
  input  logic             memIsStore,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbIsAlu,
  input  logic             wbIsLoad,
  output ctlStrobe_t       strobe
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] srcReg  [SRC_N];
  logic             srcLive [SRC_N];
  srcHit_t          hitVec  [SRC_N];

  logic memLive, wbWrites, wbLive, idReadsRs1;

  assign memLive    = memRd != ZERO_REG;
  assign wbWrites   = wbIsAlu | wbIsLoad;
  assign wbLive     = wbWrites && (wbRd != ZERO_REG);
  assign idReadsRs1 = idIsAlu | idIsLoad | idIsStore;

  always_comb begin
    srcReg[SRC_A]  = exRs1;
    srcReg[SRC_B]  = exRs2;
    srcReg[SRC_S]  = exRs2;
    srcLive[SRC_A] = exIsAlu | exIsLoad | exIsStore;
    srcLive[SRC_B] = exIsAlu;
    srcLive[SRC_S] = exIsStore;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : gSrc
    always_comb begin
      hitVec[g].newAlu  = srcLive[g] && memIsAlu  && memLive && (memRd == srcReg[g]);
      hitVec[g].newLoad = srcLive[g] && memIsLoad && memLive && (memRd == srcReg[g]);
      hitVec[g].oldHit  = srcLive[g] && wbLive && (wbRd == srcReg[g]);
    end
  end

  always_comb begin
    for (int i = 0; i < SRC_N; i++) strobe.hit[i] = hitVec[i];
    strobe.loadUse   = exIsLoad && (exRd != ZERO_REG) &&
                       (((idRs1 == exRd) && idReadsRs1) ||
                        ((idRs2 == exRd) && idIsAlu));
    strobe.lateStore = memIsStore && wbIsLoad && (wbRd != ZERO_REG) &&
                       (wbRd == memRs2);
  end
endmodule

// File: rtl/fwdDatapath.sv
module fwdDatapath
  import hazard_pkg::*;
(
  input  ctlStrobe_t strobe,
  output logic       pcWrite,
  output logic       ifIdWrite,
  output logic       idExFlush,
  output logic [1:0] aluSelA,
  output logic [1:0] aluSelB,
  output logic [1:0] exStoreSel,
  output logic       memStoreFwd
);
  fwdSel_t selVec [SRC_N];

  function automatic fwdSel_t pickSrc(input srcHit_t h);
    if (h.newAlu)       return SEL_EXMEM;
    else if (h.newLoad) return SEL_REG;
    else if (h.oldHit)  return SEL_MEMWB;
    else                return SEL_REG;
  endfunction

  for (genvar g = 0; g < SRC_N; g++) begin : gSel
    assign selVec[g] = pickSrc(strobe.hit[g]);
  end

  assign aluSelA     = selVec[SRC_A];
  assign aluSelB     = selVec[SRC_B];
  assign exStoreSel  = selVec[SRC_S];
  assign pcWrite     = !strobe.loadUse;
  assign ifIdWrite   = !strobe.loadUse;
  assign idExFlush   = strobe.loadUse;
  assign memStoreFwd = strobe.lateStore;
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idIsAlu,
  input  logic             idIsLoad,
  input  logic             idIsStore,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exIsAlu,
  input  logic             exIsLoad,
  input  logic             exIsStore,
  input  logic [REG_W-1:0] memRd,
  input  logic [REG_W-1:0] memRs2,
  input  logic             memIsAlu,
  input  logic             memIsLoad,
  input  logic             memIsStore,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbIsAlu,
  input  logic             wbIsLoad,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             idExFlush,
  output logic [1:0]       aluSelA,
  output logic [1:0]       aluSelB,
  output logic [1:0]       exStoreSel,
  output logic             memStoreFwd
);
  ctlStrobe_t strobe;

  hazardCtl #(.REG_W(REG_W)) uCtl (
    .idRs1(idRs1), .idRs2(idRs2), .idIsAlu(idIsAlu), .idIsLoad(idIsLoad),
    .idIsStore(idIsStore), .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd),
    .exIsAlu(exIsAlu), .exIsLoad(exIsLoad), .exIsStore(exIsStore),
    .memRd(memRd), .memRs2(memRs2), .memIsAlu(memIsAlu),
    .memIsLoad(memIsLoad), .memIsStore(memIsStore), .wbRd(wbRd),
    .wbIsAlu(wbIsAlu), .wbIsLoad(wbIsLoad), .strobe(strobe)
  );

  fwdDatapath uDp (
    .strobe(strobe), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .idExFlush(idExFlush), .aluSelA(aluSelA), .aluSelB(aluSelB),
    .exStoreSel(exStoreSel), .memStoreFwd(memStoreFwd)
  );
endmodule

// File: rtl/hazardChk.sv
module hazardChk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] idRs1,
  input logic             idIsAlu,
  input logic             idIsLoad,
  input logic             idIsStore,
  input logic [REG_W-1:0] exRs1,
  input logic [REG_W-1:0] exRd,
  input logic             exIsAlu,
  input logic             exIsLoad,
  input logic [REG_W-1:0] memRd,
  input logic [REG_W-1:0] memRs2,
  input logic             memIsAlu,
  input logic             memIsStore,
  input logic [REG_W-1:0] wbRd,
  input logic             wbIsAlu,
  input logic             wbIsLoad,
  input logic             pcWrite,
  input logic             ifIdWrite,
  input logic             idExFlush,
  input logic [1:0]       aluSelA,
  input logic             memStoreFwd
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    // R1
    stall_shape_chk: assert (pcWrite == ifIdWrite && idExFlush == !pcWrite);
    // R1
    stall_cause_chk: assert (!idExFlush || (exIsLoad && exRd != ZERO_REG));
    // R2
    store_data_nostall_chk: assert (!(exIsLoad && idIsStore && !idIsAlu &&
                                      !idIsLoad && idRs1 != exRd) || !idExFlush);
    // R3
    exmem_src_chk: assert (aluSelA != 2'b01 ||
                           (memIsAlu && memRd == exRs1 && memRd != ZERO_REG));
    // R4
    memwb_src_chk: assert (aluSelA != 2'b10 ||
                           ((wbIsAlu || wbIsLoad) && wbRd == exRs1 && wbRd != ZERO_REG));
    // R5
    newest_wins_chk: assert (!(exIsAlu && memIsAlu && memRd != ZERO_REG &&
                               memRd == exRs1) || aluSelA == 2'b01);
    // R10
    late_store_chk: assert (!memStoreFwd ||
                            (memIsStore && wbIsLoad && wbRd == memRs2));
  end
endmodule

bind hazardUnit hazardChk #(.REG_W(REG_W)) uChk (.*);

// File: tb/sim_hazardUnit.sv
module sim_hazardUnit;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, memRs2, wbRd;
  logic idIsAlu, idIsLoad, idIsStore, exIsAlu, exIsLoad, exIsStore;
  logic memIsAlu, memIsLoad, memIsStore, wbIsAlu, wbIsLoad;
  logic pcWrite, ifIdWrite, idExFlush, memStoreFwd;
  logic [1:0] aluSelA, aluSelB, exStoreSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazardUnit #(.REG_W(REG_W)) u0 (.*);

  task automatic clearAll();
    @(posedge clk);
    {idRs1, idRs2, exRs1, exRs2, exRd, memRd, memRs2, wbRd} = '0;
    {idIsAlu, idIsLoad, idIsStore, exIsAlu, exIsLoad, exIsStore} = '0;
    {memIsAlu, memIsLoad, memIsStore, wbIsAlu, wbIsLoad} = '0;
  endtask

  task automatic expectOut(input string req, input logic pc, input logic ifid,
                           input logic fl, input logic [1:0] a,
                           input logic [1:0] b, input logic [1:0] s,
                           input logic late);
    logic [9:0] act, exp;
    @(negedge clk);
    act = {pcWrite, ifIdWrite, idExFlush, aluSelA, aluSelB, exStoreSel, memStoreFwd};
    exp = {pc, ifid, fl, a, b, s, late};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic testIdle();
    clearAll();
    expectOut("R1 idle", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
  endtask

  task automatic testLoadUse();
    clearAll(); exIsLoad = 1; exRd = 3; idIsAlu = 1; idRs1 = 3;
    expectOut("R1 alu rs1", 0, 0, 1, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); exIsLoad = 1; exRd = 3; idIsAlu = 1; idRs1 = 4; idRs2 = 3;
    expectOut("R1 alu rs2", 0, 0, 1, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); exIsLoad = 1; exRd = 3; idIsStore = 1; idRs1 = 3; idRs2 = 9;
    expectOut("R1 store addr", 0, 0, 1, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); exIsLoad = 1; exRd = 3; idIsStore = 1; idRs1 = 4; idRs2 = 3;
    expectOut("R2 store data", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); exIsLoad = 1; exRd = 0; idIsAlu = 1; idRs1 = 0;
    expectOut("R7 load r0", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
  endtask

  task automatic testAluBypass();
    clearAll(); exIsAlu = 1; exRs1 = 5; memIsAlu = 1; memRd = 5;
    expectOut("R3 opA", 1, 1, 0, 2'b01, 2'b00, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs2 = 5; memIsAlu = 1; memRd = 5;
    expectOut("R3 opB", 1, 1, 0, 2'b00, 2'b01, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs1 = 6; wbIsLoad = 1; wbRd = 6;
    expectOut("R4 load opA", 1, 1, 0, 2'b10, 2'b00, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs2 = 6; wbIsAlu = 1; wbRd = 6;
    expectOut("R4 alu opB", 1, 1, 0, 2'b00, 2'b10, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs1 = 7; memIsAlu = 1; memRd = 7; wbIsAlu = 1; wbRd = 7;
    expectOut("R5 newest", 1, 1, 0, 2'b01, 2'b00, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs1 = 8; exRs2 = 9;
    memIsAlu = 1; memRd = 8; wbIsLoad = 1; wbRd = 9;
    expectOut("R6 both", 1, 1, 0, 2'b01, 2'b10, 2'b00, 0);
  endtask

  task automatic testZeroAndDistance();
    clearAll(); exIsAlu = 1; exRs1 = 0; exRs2 = 0;
    memIsAlu = 1; memRd = 0; wbIsAlu = 1; wbRd = 0;
    expectOut("R7 r0 bypass", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); wbIsAlu = 1; wbRd = 10; idIsAlu = 1; idRs1 = 10; idRs2 = 10;
    exIsAlu = 1; exRs1 = 2; exRs2 = 3;
    expectOut("R8 wb to id", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
  endtask

  task automatic testStoreData();
    clearAll(); exIsStore = 1; exRs2 = 11; memIsAlu = 1; memRd = 11;
    expectOut("R9 store exmem", 1, 1, 0, 2'b00, 2'b00, 2'b01, 0);
    clearAll(); exIsStore = 1; exRs2 = 11; wbIsAlu = 1; wbRd = 11;
    expectOut("R9 store memwb", 1, 1, 0, 2'b00, 2'b00, 2'b10, 0);
    clearAll(); exIsAlu = 1; exRs2 = 11; memIsAlu = 1; memRd = 11;
    expectOut("R9 not store", 1, 1, 0, 2'b00, 2'b01, 2'b00, 0);
    clearAll(); exIsStore = 1; exRs2 = 12; memIsLoad = 1; memRd = 12;
    wbIsAlu = 1; wbRd = 12;
    expectOut("R10 load defers", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); memIsStore = 1; memRs2 = 12; wbIsLoad = 1; wbRd = 12;
    expectOut("R10 late fwd", 1, 1, 0, 2'b00, 2'b00, 2'b00, 1);
    clearAll(); memIsStore = 1; memRs2 = 12; wbIsAlu = 1; wbRd = 12;
    expectOut("R10 late alu", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
  endtask

  task automatic testBubble();
    clearAll(); exRs1 = 13; exRs2 = 13; memIsAlu = 1; memRd = 13;
    expectOut("R11 bubble", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
    clearAll(); exIsAlu = 1; exRs1 = 14; memIsStore = 1; memRd = 14;
    expectOut("R11 store src", 1, 1, 0, 2'b00, 2'b00, 2'b00, 0);
  endtask

  initial begin
    testIdle();
    testLoadUse();
    testAluBypass();
    testZeroAndDistance();
    testStoreData();
    testBubble();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule